// File: doc/BRIEF.md
# Host-Side Serial Slave with Acquisition Lockout

This block is the slave end of a two-wire serial link. Through it a host microcontroller reads a bank of bytes captured by an acquisition engine and writes a bank of control bytes. The device answers to one of two address pairs. A static select pin chooses the pair. The block never drives the clock line. On the data line it only pulls low, through an output-enable (`sda_oe_o` high means the pad pulls SDA to 0).

While a transaction that is addressed to this device is open, the block holds `lock_o` high. The acquisition side must not change `rd_bank_i` while the lock is held, so a host read never mixes old and new bytes. A byte pointer selects the bank entry for both reads and writes. The first data byte of a write sets the pointer. Each byte read or written afterwards advances it, and it wraps at the end of the bank.

Both bus lines pass through two synchronising flip-flops and are edge-detected in the system clock domain. A start or stop is an SDA edge while SCL is high. The controller is a state machine with these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WR_BYTE`, `ST_WR_ACK`, `ST_RD_BYTE`, `ST_RD_ACK` and `ST_IGNORE`. Its transitions are:

- **Any state, start:** go to `ST_ADDR`.
- **Any state, stop:** go to `ST_IDLE`.
- **`ST_ADDR`, eighth bit done:** on a match, go to `ST_ADDR_ACK`. On a mismatch, go to `ST_IGNORE`.
- **`ST_ADDR_ACK`:** for a read, go to `ST_RD_BYTE`. For a write, go to `ST_WR_BYTE`.
- **Write loop:** `ST_WR_BYTE` goes to `ST_WR_ACK`, which returns to `ST_WR_BYTE`.
- **Read loop:** `ST_RD_BYTE` goes to `ST_RD_ACK`. If the master acknowledged, it returns to `ST_RD_BYTE`. If the master did not acknowledge, it goes to `ST_IGNORE`.

Top module: `i2c_lock_slave`

## Requirements
- R1: With `sel_i` low, the device answers to the 8-bit address bytes 0x20 (write) and 0x21 (read). With `sel_i` high, it answers to 0x22 and 0x23. Any other address byte gets no acknowledge, does not raise `lock_o`, and leaves the written bank unchanged.
- R2: The slave acknowledges a matching address byte and every written data byte by holding `sda_oe_o` high through the ninth SCL pulse.
- R3: The first data byte of a write loads the pointer with that byte modulo NREG. Each later byte is stored in `wr_regs_o[ptr*8 +: 8]`, and the pointer then advances. The pointer is kept between transactions.
- R4: A read returns `rd_bank_i[ptr*8 +: 8]` MSB first. A 0 bit is shown by `sda_oe_o` high. The pointer advances after each byte. A master acknowledge (SDA low on the ninth pulse) starts the next byte. A not-acknowledge makes the slave release SDA until the next start.
- R5: Advancing the pointer from NREG-1 wraps it to 0, for both reads and writes.
- R6: `lock_o` rises when an address byte matches. It falls on a stop. It stays high across a repeated start that addresses this device again. It falls when a repeated start is followed by a non-matching address.
- R7: `sda_oe_o` never changes while SCL is high. It changes only after a detected SCL falling edge, or on a start or stop.
- R8: A stop in the middle of a byte aborts the transfer. SDA is released, `lock_o` falls, and the partial byte is discarded. A pointer value already loaded is kept.
- R9: After reset, `sda_oe_o` and `lock_o` are low, every written byte is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sel_i | input | 1 | Static address-pair select |
| rd_bank_i | input | NREG*8 | Captured bytes from the acquisition side, byte k at bits k*8+7:k*8 |
| sda_oe_o | output | 1 | Pull SDA low when high |
| lock_o | output | 1 | Acquisition update inhibit |
| wr_regs_o | output | NREG*8 | Bytes written by the host, byte k at bits k*8+7:k*8 |

## Verification
The hardest state to reach from the ports is a lock that must survive a repeated start. This happens when a pointer write is followed by a read without an intervening stop, and in the contrasting case where a repeated start leads to a foreign address and must drop the lock. The stimulus drives a wired-AND bus model and issues a repeated start directly after a write acknowledge. It also aborts a byte with a stop after four bits. In each case it checks that the pointer and the written bank still match the behavioural model on the next read.

// File: rtl/i2cl_pkg.sv
package i2cl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    // upper seven address bits shared by both pairs; select pin fills bit 0
    localparam logic [6:0] DEV_BASE = 7'h10;
endpackage

// File: rtl/i2cl_sync.sv
module i2cl_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], raw_i[g]};
        end
        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/i2cl_regs.sv
module i2cl_regs #(
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ptr_load_i,
    input  logic            ptr_inc_i,
    input  logic            wr_en_i,
    input  logic [7:0]      din_i,
    input  logic [NREG*8-1:0] rd_bank_i,
    output logic [7:0]      rd_byte_o,
    output logic [NREG*8-1:0] wr_regs_o
);
    localparam int PW = (NREG > 2) ? $clog2(NREG) : 1;
    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr_q <= '0;
        else if (ptr_load_i) ptr_q <= PW'(din_i % 8'(NREG));
        else if (ptr_inc_i)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign rd_byte_o = rd_bank_i[int'(ptr_q)*8 +: 8];

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               byte_q <= '0;
            else if (wr_en_i && ptr_q == PW'(g))      byte_q <= din_i;
        end
        assign wr_regs_o[g*8 +: 8] = byte_q;
    end

    // R5: the pointer wraps from the last entry to the first
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc_i && !ptr_load_i && ptr_q == LAST) |=> (ptr_q == '0));

    // R3: the written bank only moves on a write strobe
    a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(wr_regs_o));
endmodule

// File: rtl/i2c_lock_slave.sv
module i2c_lock_slave #(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sel_i,
    input  logic [NREG*8-1:0] rd_bank_i,
    output logic              sda_oe_o,
    output logic              lock_o,
    output logic [NREG*8-1:0] wr_regs_o
);
    import i2cl_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [1:0] lvl, rise, fall;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    i2cl_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl  = lvl[0];
    assign sda_lvl  = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign start_ev = fall[1] & scl_lvl & ~scl_rise;
    assign stop_ev  = rise[1] & scl_lvl & ~scl_rise;

    bus_state_e st_q, st_d;
    logic [3:0] bit_q, bit_d;
    logic [7:0] sh_q, sh_d;
    logic oe_q, oe_d, lock_q, lock_d, rw_q, rw_d, first_q, first_d, nack_q, nack_d;
    logic ptr_load, ptr_inc, wr_en;
    logic [7:0] rd_byte;
    logic [6:0] dev_addr;

    assign dev_addr = DEV_BASE | {6'b0, sel_i};

    i2cl_regs #(.NREG(NREG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_load_i (ptr_load),
        .ptr_inc_i  (ptr_inc),
        .wr_en_i    (wr_en),
        .din_i      (sh_q),
        .rd_bank_i  (rd_bank_i),
        .rd_byte_o  (rd_byte),
        .wr_regs_o  (wr_regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            oe_q    <= 1'b0;
            lock_q  <= 1'b0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nack_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            oe_q    <= oe_d;
            lock_q  <= lock_d;
            rw_q    <= rw_d;
            first_q <= first_d;
            nack_q  <= nack_d;
        end
    end

    // next state, next outputs and bank strobes
    always_comb begin
        st_d     = st_q;
        bit_d    = bit_q;
        sh_d     = sh_q;
        oe_d     = oe_q;
        lock_d   = lock_q;
        rw_d     = rw_q;
        first_d  = first_q;
        nack_d   = nack_q;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        wr_en    = 1'b0;
        if (stop_ev) begin
            st_d   = ST_IDLE;
            oe_d   = 1'b0;
            lock_d = 1'b0;
        end else if (start_ev) begin
            st_d  = ST_ADDR;
            bit_d = '0;
            oe_d  = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_IGNORE: begin
                    oe_d = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[6:0], sda_lvl};
                        bit_d = bit_q + 4'd1;
                    end else if (scl_fall && bit_q == 4'd8) begin
                        if (sh_q[7:1] == dev_addr) begin
                            lock_d  = 1'b1;
                            oe_d    = 1'b1;
                            rw_d    = sh_q[0];
                            first_d = 1'b1;
                            st_d    = ST_ADDR_ACK;
                        end else begin
                            lock_d = 1'b0;
                            st_d   = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        if (rw_q) begin
                            sh_d = rd_byte;
                            oe_d = ~rd_byte[7];
                            st_d = ST_RD_BYTE;
                        end else begin
                            oe_d = 1'b0;
                            st_d = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[6:0], sda_lvl};
                        bit_d = bit_q + 4'd1;
                    end else if (scl_fall && bit_q == 4'd8) begin
                        oe_d = 1'b1;
                        st_d = ST_WR_ACK;
                        if (first_q) begin
                            ptr_load = 1'b1;
                            first_d  = 1'b0;
                        end else begin
                            wr_en   = 1'b1;
                            ptr_inc = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        oe_d  = 1'b0;
                        bit_d = '0;
                        st_d  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bit_d = bit_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_q == 4'd8) begin
                            oe_d    = 1'b0;
                            ptr_inc = 1'b1;
                            st_d    = ST_RD_ACK;
                        end else begin
                            sh_d = {sh_q[6:0], 1'b0};
                            oe_d = ~sh_q[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        nack_d = sda_lvl;
                    end else if (scl_fall) begin
                        bit_d = '0;
                        if (nack_q) begin
                            oe_d = 1'b0;
                            st_d = ST_IGNORE;
                        end else begin
                            sh_d = rd_byte;
                            oe_d = ~rd_byte[7];
                            st_d = ST_RD_BYTE;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = oe_q;
    assign lock_o   = lock_q;

    // R7: the data-line drive moves only after an SCL fall, a start or a stop
    a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> $past(scl_fall | start_ev | stop_ev));

    // R6: a stop always drops the lock
    a_r6_stop_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !lock_q);

    // R6: the lock only rises out of address decoding
    a_r6_lock_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(st_q == ST_ADDR && scl_fall));

    // R1: an unaddressed or idle slave never pulls the data line
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_IGNORE) |-> !oe_q);
endmodule

// File: tb/sim_i2c_lock_slave.sv
module sim_i2c_lock_slave;
    localparam int NREG = 8;
    localparam int Q    = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel   = 1'b0;
    logic [NREG*8-1:0] bank;
    logic oe, lock;
    logic [NREG*8-1:0] wr_regs;
    wire  sda_line = sda_m & ~oe;

    i2c_lock_slave #(.NREG(NREG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sel_i     (sel),
        .rd_bank_i (bank),
        .sda_oe_o  (oe),
        .lock_o    (lock),
        .wr_regs_o (wr_regs)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int r7_viol = 0;
    logic oe_prev = 1'b0;

    // behavioural model state
    logic [7:0] exp_wr [NREG];
    int exp_ptr = 0;

    function automatic logic [7:0] bank_byte(int i);
        return 8'((i * 37 + 90) & 255);
    endfunction

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_wr[i];
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        r = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(~give_ack, r);
    endtask

    // model of a data byte written after the pointer byte
    task automatic model_data(input logic [7:0] b, input bit first);
        if (first) exp_ptr = int'(b) % NREG;
        else begin
            exp_wr[exp_ptr] = b;
            exp_ptr = (exp_ptr + 1) % NREG;
        end
    endtask

    task automatic read_expect(input logic give_ack, input string req);
        logic [7:0] v;
        rbyte(give_ack, v);
        check(req, 64'(v), 64'(bank_byte(exp_ptr)));
        exp_ptr = (exp_ptr + 1) % NREG;
    endtask

    // R7 monitor: the drive must stay put while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl_m && oe !== oe_prev) r7_viol++;
        oe_prev = oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) begin
            bank[i*8 +: 8] = bank_byte(i);
            exp_wr[i] = 8'h00;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();

        // R9 reset state
        check("R9 oe", 64'(oe), 64'd0);
        check("R9 lock", 64'(lock), 64'd0);
        check("R9 wr_regs", 64'(wr_regs), 64'(exp_flat()));

        // select low, write pointer 2 then two bytes
        sel = 1'b0; wq();
        bus_start();
        wbyte(8'h20, a); check("R1 ack 0x20 sel low", 64'(a), 64'd1);
        check("R6 lock after match", 64'(lock), 64'd1);
        wbyte(8'h02, a); check("R2 ack pointer byte", 64'(a), 64'd1); model_data(8'h02, 1);
        wbyte(8'hA5, a); check("R2 ack data byte", 64'(a), 64'd1); model_data(8'hA5, 0);
        wbyte(8'h3C, a); check("R2 ack data byte", 64'(a), 64'd1); model_data(8'h3C, 0);
        check("R6 lock held mid write", 64'(lock), 64'd1);
        bus_stop(); wq();
        check("R6 lock after stop", 64'(lock), 64'd0);
        check("R3 written bank", 64'(wr_regs), 64'(exp_flat()));

        // foreign address for this select value
        bus_start();
        wbyte(8'h22, a); check("R1 no ack 0x22 sel low", 64'(a), 64'd0);
        check("R1 no lock on mismatch", 64'(lock), 64'd0);
        wbyte(8'h55, a); check("R1 no ack ignored data", 64'(a), 64'd0);
        bus_stop(); wq();
        check("R1 bank untouched", 64'(wr_regs), 64'(exp_flat()));

        // select high, write across the end of the bank
        sel = 1'b1; wq();
        bus_start();
        wbyte(8'h22, a); check("R1 ack 0x22 sel high", 64'(a), 64'd1);
        wbyte(8'h07, a); model_data(8'h07, 1);
        wbyte(8'h11, a); model_data(8'h11, 0);
        wbyte(8'h22, a); model_data(8'h22, 0);
        bus_stop(); wq();
        check("R5 write wrap", 64'(wr_regs), 64'(exp_flat()));

        // pointer write, repeated start, read three bytes across the wrap
        bus_start();
        wbyte(8'h22, a);
        wbyte(8'h06, a); model_data(8'h06, 1);
        bus_rstart();
        check("R6 lock across repeated start", 64'(lock), 64'd1);
        wbyte(8'h23, a); check("R1 ack 0x23 sel high", 64'(a), 64'd1);
        read_expect(1'b1, "R4 read byte");
        read_expect(1'b1, "R4 read byte");
        read_expect(1'b0, "R5 read wrap");
        wq();
        check("R4 released after nack", 64'(oe), 64'd0);
        check("R6 lock until stop", 64'(lock), 64'd1);
        bus_stop(); wq();
        check("R6 lock after read stop", 64'(lock), 64'd0);

        // low-pair addresses are foreign while select is high
        bus_start();
        wbyte(8'h20, a); check("R1 no ack 0x20 sel high", 64'(a), 64'd0);
        bus_stop();
        bus_start();
        wbyte(8'h21, a); check("R1 no ack 0x21 sel high", 64'(a), 64'd0);
        bus_stop(); wq();

        // repeated start to another device drops the lock
        bus_start();
        wbyte(8'h22, a);
        check("R6 lock before re-address", 64'(lock), 64'd1);
        bus_rstart();
        wbyte(8'h40, a); check("R6 foreign re-address not acked", 64'(a), 64'd0);
        check("R6 lock dropped on foreign re-address", 64'(lock), 64'd0);
        bus_stop(); wq();

        // stop in the middle of a data byte
        bus_start();
        wbyte(8'h22, a);
        wbyte(8'h05, a); model_data(8'h05, 1);
        bus_bit(1'b1, a); bus_bit(1'b0, a); bus_bit(1'b1, a); bus_bit(1'b1, a);
        bus_stop(); wq();
        check("R8 lock after abort", 64'(lock), 64'd0);
        check("R8 oe after abort", 64'(oe), 64'd0);
        check("R8 bank unchanged", 64'(wr_regs), 64'(exp_flat()));
        bus_start();
        wbyte(8'h23, a);
        read_expect(1'b0, "R8 pointer kept after abort");
        bus_stop(); wq();

        // select low read pair
        sel = 1'b0; wq();
        bus_start();
        wbyte(8'h21, a); check("R1 ack 0x21 sel low", 64'(a), 64'd1);
        read_expect(1'b1, "R4 read after ack");
        read_expect(1'b0, "R4 read last");
        bus_stop(); wq();

        check("R7 drive changes while SCL high", 64'(r7_viol), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule